// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns parallel characters from a processor into a serial bit stream on `txd`. The bit clock is an external transmit clock, `txc`, which the block samples on its own system clock. Each falling edge of `txc` is a possible bit boundary. In synchronous mode every falling edge starts a new bit. In asynchronous mode a bit lasts 1, 16 or 64 transmit-clock periods, and each character is framed with a start bit, an optional parity bit and one or two stop bits.

The processor writes into a one-character holding register. A separate frame register shifts the character out, so a second character can wait while the first is on the line. Two conditions must both hold for the transmitter to take a write: the clear-to-send input `cts_n` must be low and the command enable `tx_en` must be high. Removing either one stops new writes from being taken. Any character already taken is still sent in full. In synchronous mode an idle gap between characters is filled with a programmed sync character while the transmitter stays enabled. Mode and command decoding are done elsewhere and arrive here as plain inputs.

Top module: `serial_tx_cts`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, and `tx_rdy` is 0 as long as `tx_en` stays 0.
- R2: `tx_rdy` is 1 exactly when `tx_en` is 1, `cts_n` is 0 and no character is waiting in the holding register.
- R3: `txd` changes only in the system-clock cycle after a falling edge of `txc` is seen, or when `brk` changes. In synchronous mode (`sync_mode`=1) each bit lasts one `txc` period.
- R4: In asynchronous mode each bit lasts F periods of `txc`, where `baud_sel` selects F: 0 gives 1, 1 gives 16, and 2 or 3 give 64.
- R5: An asynchronous frame is sent in this order: a 0 start bit, then 5+`char_len` data bits LSB first, then a parity bit if `par_en`=1, then one stop bit of 1 (two if `stop2`=1). The parity bit is the XOR of the data bits, inverted when `par_odd`=1.
- R6: A synchronous frame has no start or stop bits. It is the data bits LSB first, followed by the parity bit when `par_en`=1.
- R7: A character waiting in the holding register starts on the bit boundary right after the last bit of the frame before it, with no idle bit between the two frames.
- R8: In synchronous mode, if a frame ends while the transmitter is enabled and the holding register is empty, `sync_char` is sent next as a frame. No fill frame starts while the transmitter is disabled.
- R9: Once a character has been accepted, it is sent in full even if `cts_n` rises or `tx_en` falls before or during its frame. This holds whether the character is still in the holding register or already being shifted.
- R10: A write made while `tx_rdy` is 0 is dropped. If the transmitter was empty, `tx_empty` stays 1 and `txd` stays 1.
- R11: `tx_empty` is 1 exactly when no accepted data character is waiting or being shifted. A sync fill frame does not count as a data character.
- R12: While `brk` is 1, `txd` is 0. When no frame is being shifted and `brk` is 0, `txd` is at the mark level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txc | input | 1 | Transmit bit clock; falling edges mark bit boundaries |
| cts_n | input | 1 | Clear to send, active low |
| tx_en | input | 1 | Command-level transmit enable |
| brk | input | 1 | Force the line low |
| sync_mode | input | 1 | 1 = synchronous framing, 0 = asynchronous |
| baud_sel | input | 2 | Asynchronous clock factor select |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| stop2 | input | 1 | Two stop bits when 1 |
| sync_char | input | 8 | Fill character for synchronous gaps |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial data out |
| tx_rdy | output | 1 | A write would be accepted |
| tx_empty | output | 1 | No data character waiting or in flight |

## Verification
The assertions check on every cycle that `txd` moves only after a falling `txc` edge or a change of `brk`, and that a running frame never stops between edges, so a disable cannot cut a frame short. They also check that an accepted write clears `tx_empty`, that a refused write leaves an empty transmitter empty, and that in synchronous mode every falling edge advances one bit. Only the bench scenarios can show the bit order, parity values, stop-bit counts and the three clock factors. The same is true of back-to-back framing with no gap, a single sync fill ending after a disable, characters accepted before a `cts_n` rise still being sent, and a write made while disabled producing nothing on the line.

// File: rtl/stx_pkg.sv
package stx_pkg;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [LEN_W-1:0]   left;
        logic               active;
        logic               carries_data;
        logic [DATA_W-1:0]  hold;
        logic               hold_full;
    } tx_state_t;
endpackage

// File: rtl/stx_frame_build.sv
module stx_frame_build
    import stx_pkg::*;
(
    input  logic [DATA_W-1:0]  data,
    input  logic [1:0]         char_len,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               stop2,
    input  logic               sync_mode,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   len
);
    logic [LEN_W-1:0] nbits;
    logic [LEN_W-1:0] pos;
    logic             par;

    // Bits are placed from bit 0 upward; bit 0 leaves the line first.
    always_comb begin
        nbits = LEN_W'(5) + LEN_W'(char_len);
        frame = '1;
        pos   = '0;
        par   = 1'b0;
        if (!sync_mode) begin
            frame[0] = 1'b0;
            pos      = LEN_W'(1);
        end
        for (int i = 0; i < DATA_W; i++) begin
            if (LEN_W'(i) < nbits) begin
                frame[pos] = data[i];
                par        = par ^ data[i];
                pos        = pos + LEN_W'(1);
            end
        end
        if (par_en) begin
            frame[pos] = par ^ par_odd;
            pos        = pos + LEN_W'(1);
        end
        if (!sync_mode) begin
            pos = pos + (stop2 ? LEN_W'(2) : LEN_W'(1));
        end
        len = pos;
    end
endmodule

// File: rtl/stx_baud_tick.sv
module stx_baud_tick #(
    parameter int FACT_MID = 16,
    parameter int FACT_HI  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       txc,
    input  logic       sync_mode,
    input  logic [1:0] baud_sel,
    input  logic       active,
    input  logic       restart,
    output logic       tick,
    output logic       bit_step
);
    localparam int CNT_W = $clog2(FACT_HI);

    logic             txc_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_cnt;

    assign tick = txc_q & ~txc;

    always_comb begin
        if (sync_mode) begin
            last_cnt = '0;
        end else begin
            case (baud_sel)
                2'd0:    last_cnt = '0;
                2'd1:    last_cnt = CNT_W'(FACT_MID - 1);
                default: last_cnt = CNT_W'(FACT_HI - 1);
            endcase
        end
    end

    assign bit_step = tick & active & (cnt_q >= last_cnt);

    always_comb begin
        cnt_d = cnt_q;
        if (restart || !active) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = (cnt_q >= last_cnt) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txc_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            txc_q <= txc;
            cnt_q <= cnt_d;
        end
    end

    // R3: in synchronous mode each falling edge of a running frame is a bit boundary
    a_r3_sync_every_edge: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && active && tick) |-> bit_step);
endmodule

// File: rtl/serial_tx_cts.sv
module serial_tx_cts
    import stx_pkg::*;
#(
    parameter int FACT_MID = 16,
    parameter int FACT_HI  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txc,
    input  logic              cts_n,
    input  logic              tx_en,
    input  logic              brk,
    input  logic              sync_mode,
    input  logic [1:0]        baud_sel,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic [DATA_W-1:0] sync_char,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_empty
);
    tx_state_t st_d, st_q;

    logic               tick, bit_step;
    logic               enabled, accept;
    logic               frame_end, start_slot, load_data, load_fill;
    logic [DATA_W-1:0]  src_data;
    logic [FRAME_W-1:0] new_frame;
    logic [LEN_W-1:0]   new_len;

    stx_baud_tick #(
        .FACT_MID (FACT_MID),
        .FACT_HI  (FACT_HI)
    ) i_tick (
        .clk       (clk),
        .rst       (rst),
        .txc       (txc),
        .sync_mode (sync_mode),
        .baud_sel  (baud_sel),
        .active    (st_q.active),
        .restart   (load_data | load_fill),
        .tick      (tick),
        .bit_step  (bit_step)
    );

    assign src_data = load_data ? st_q.hold : sync_char;

    stx_frame_build i_build (
        .data      (src_data),
        .char_len  (char_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop2     (stop2),
        .sync_mode (sync_mode),
        .frame     (new_frame),
        .len       (new_len)
    );

    assign enabled    = tx_en & ~cts_n;
    assign tx_rdy     = enabled & ~st_q.hold_full;
    assign accept     = wr_en & tx_rdy;
    assign frame_end  = bit_step & (st_q.left == LEN_W'(1));
    assign start_slot = (tick & ~st_q.active) | frame_end;
    assign load_data  = start_slot & st_q.hold_full;
    assign load_fill  = start_slot & ~st_q.hold_full & st_q.active & sync_mode & enabled;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.hold_full = 1'b1;
            st_d.hold      = wr_data;
        end
        if (load_data || load_fill) begin
            st_d.frame        = new_frame;
            st_d.left         = new_len;
            st_d.active       = 1'b1;
            st_d.carries_data = load_data;
            if (load_data) begin
                st_d.hold_full = 1'b0;
            end
        end else if (frame_end) begin
            st_d.active       = 1'b0;
            st_d.carries_data = 1'b0;
            st_d.frame        = '1;
            st_d.left         = '0;
        end else if (bit_step) begin
            st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
            st_d.left  = st_q.left - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.frame        <= '1;
            st_q.left         <= '0;
            st_q.active       <= 1'b0;
            st_q.carries_data <= 1'b0;
            st_q.hold         <= '0;
            st_q.hold_full    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd      = brk ? 1'b0 : (st_q.active ? st_q.frame[0] : 1'b1);
    assign tx_empty = ~st_q.hold_full & ~st_q.carries_data;

    // R3: the line only moves on a detected falling edge of txc or a break change
    a_r3_moves_on_edge: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (txd == $past(txd)) || (brk != $past(brk)));

    // R9: a running frame cannot stop between bit boundaries, whatever the enables do
    a_r9_frame_not_cut: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && !tick) |=> st_q.active);

    // R11: an accepted write makes the transmitter non-empty
    a_r11_accept_fills: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tx_rdy) |=> !tx_empty);

    // R10: a refused write leaves an empty transmitter empty
    a_r10_refused_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tx_rdy && tx_empty) |=> tx_empty);
endmodule

// File: tb/test_serial_tx_cts.sv
module test_serial_tx_cts;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txc = 1'b1;
    logic       cts_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk = 1'b0;
    logic       sync_mode = 1'b0;
    logic [1:0] baud_sel = 2'd0;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop2 = 1'b0;
    logic [7:0] sync_char = 8'h16;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_rdy, tx_empty;

    int    n_chk = 0;
    int    n_bad = 0;
    int    fact = 1;
    string mon_req = "R5";
    bit    exp_q[$];
    bit    mon_busy = 1'b0;

    always #4 clk = ~clk;                       // 125 MHz
    initial forever #32 txc = ~txc;             // edges fall on clk negedges

    serial_tx_cts i_serial_tx_cts (
        .clk(clk), .rst(rst), .txc(txc), .cts_n(cts_n), .tx_en(tx_en),
        .brk(brk), .sync_mode(sync_mode), .baud_sel(baud_sel),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .stop2(stop2), .sync_char(sync_char), .wr_en(wr_en),
        .wr_data(wr_data), .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver side: expected line bits for one frame, from the requirements
    task automatic push_frame(input logic [7:0] d);
        int  n;
        bit  p;
        n = 5 + int'(char_len);
        p = par_odd;
        if (!sync_mode) exp_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(d[i]);
            p ^= d[i];
        end
        if (par_en) exp_q.push_back(p);
        if (!sync_mode) begin
            exp_q.push_back(1'b1);
            if (stop2) exp_q.push_back(1'b1);
        end
    endtask

    task automatic align();
        @(posedge txc);
        @(posedge clk);
        #1;
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_rdy();
        while (!tx_rdy) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        wait (!mon_busy);
        while (!tx_empty) @(posedge clk);
        #1;
    endtask

    task automatic idle_check(input string req, input int periods);
        int lows = 0;
        for (int i = 0; i < periods; i++) begin
            @(posedge txc);
            if (txd !== 1'b1) lows++;
        end
        chk(req, lows, 0);
    endtask

    // Monitor: samples each bit at the middle of its txc window
    initial begin
        forever begin
            int r;
            bit e;
            wait (exp_q.size() > 0);
            mon_busy = 1'b1;
            r = 0;
            while (exp_q.size() > 0) begin
                @(posedge txc);
                if ((r % fact) == (fact - 1) / 2) begin
                    e = exp_q.pop_front();
                    chk(mon_req, int'(txd), int'(e));
                end
                r++;
            end
            mon_busy = 1'b0;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 tx_rdy", int'(tx_rdy), 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 after release", int'(tx_rdy), 0);
        tx_en = 1'b1;
        #1;
        chk("R2 enabled rdy", int'(tx_rdy), 1);
        cts_n = 1'b1;
        #1;
        chk("R2 cts high rdy", int'(tx_rdy), 0);
        cts_n = 1'b0;

        // R5: factor 1, 8 data, no parity, 1 stop
        fact = 1; mon_req = "R5 8N1 x1";
        align();
        push_frame(8'hA5);
        write(8'hA5);
        chk("R2 rdy low when holding full", int'(tx_rdy), 0);
        chk("R11 empty low after write", int'(tx_empty), 0);
        drain();
        idle_check("R12 mark after frame", 4);

        // R4 factor 16, R7 back to back, 7 data even parity 2 stop
        baud_sel = 2'd1; char_len = 2'd2; par_en = 1'b1; stop2 = 1'b1;
        fact = 16; mon_req = "R7 R4 x16 7E2 back-to-back";
        align();
        push_frame(8'h3C);
        push_frame(8'h51);
        write(8'h3C);
        wait_rdy();
        write(8'h51);
        drain();

        // R4 factor 64, 5 data odd parity 1 stop
        baud_sel = 2'd2; char_len = 2'd0; par_odd = 1'b1; stop2 = 1'b0;
        fact = 64; mon_req = "R4 x64 5O1";
        align();
        push_frame(8'h1B);
        write(8'h1B);
        drain();

        // R6 R8: synchronous frame then one fill frame, then disable
        sync_mode = 1'b1; char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;
        fact = 1; mon_req = "R6 R8 sync data and fill";
        align();
        push_frame(8'h96);
        push_frame(sync_char);
        write(8'h96);
        while (!tx_empty) @(posedge clk);
        #1;
        tx_en = 1'b0;
        wait (exp_q.size() == 0);
        wait (!mon_busy);
        idle_check("R8 fill stops when disabled", 20);
        tx_en = 1'b1;

        // R9: two characters accepted, then cts rises mid frame
        sync_mode = 1'b0; baud_sel = 2'd1; char_len = 2'd3;
        fact = 16; mon_req = "R9 accepted chars finish";
        align();
        push_frame(8'hC3);
        push_frame(8'h2E);
        write(8'hC3);
        wait_rdy();
        write(8'h2E);
        repeat (40) @(posedge clk);
        #1;
        cts_n = 1'b1;
        #1;
        chk("R2 rdy low under cts", int'(tx_rdy), 0);
        drain();

        // R10: write while disabled is dropped
        write(8'h00);
        chk("R10 empty stays", int'(tx_empty), 1);
        idle_check("R10 line stays mark", 40);
        chk("R10 empty after wait", int'(tx_empty), 1);
        cts_n = 1'b0;
        #1;
        chk("R10 rdy after re-enable", int'(tx_rdy), 1);
        idle_check("R10 nothing left over", 40);

        // R12 break
        brk = 1'b1;
        #1;
        chk("R12 break low", int'(txd), 0);
        repeat (3) @(posedge clk);
        #1;
        chk("R12 break held", int'(txd), 0);
        brk = 1'b0;
        #1;
        chk("R12 break release", int'(txd), 1);

        summary();
    end
endmodule